// File: doc/BRIEF.md
# Event Counter Bank with Privilege-Gated Reads

This block keeps the run-time statistics of a processor core. It has a cycle counter, a retired-instruction counter and six general counters, all 64 bits wide. Each general counter has a selector register. The selector picks one of 22 single-cycle event inputs, and the counter adds one on each cycle in which the chosen input is high. A mask register can freeze any counter. Two enable masks control whether lower privilege levels may read the counters through a read-only alias window.

Software reaches the bank through a single-cycle register port. Read data and the illegal-access flag are combinational in the cycle of the request. A write takes effect at the next clock edge. With a 32-bit register width, the upper half of each counter has its own address.

Top module: `hpm_unit`

## Requirements
- R1: Addresses have bits 11:8 zero. Bits 7:5 select the region: 0 counter low word, 1 counter high word, 2 alias low word, 3 alias high word, 4 selector, 5 control. Bits 4:0 give the slot: 0 cycles, 2 retired instructions, 3..8 general counters. In the control region, slot 0 is the freeze mask, slot 1 the machine enable mask and slot 2 the supervisor enable mask. Slot 1 in the counter and alias regions, slots other than 3..8 in the selector region, every other slot and every other address are illegal.
- R2: When its freeze bit is clear, the cycle counter adds one on every clock edge. When its freeze bit is clear, the retired-instruction counter adds one on each edge where `retire_i` is high.
- R3: A general counter adds one on each edge where the event input bit (code-1) is high, with code being its selector value in the range 1..22.
- R4: A selector write above 22 stores 0 and reads back 0. A selector of 0 never counts.
- R5: Freeze-mask bit n (n = 0, 2..8) holds counter n. Bit 1 of the freeze and enable masks always reads 0.
- R6: A write to a counter half in the same cycle as an increment loads the written value, and the increment is lost.
- R7: With a 32-bit width, a low-word write keeps the high word and a high-word write keeps the low word. A carry out of the low word reaches the high word.
- R8: The counter, selector, freeze and machine-enable regions accept only machine privilege (`priv_i` = 3). The supervisor enable mask needs supervisor (1) or machine privilege. Any other `priv_i` value counts as user.
- R9: Alias reads are always allowed at machine level. At supervisor level they need the slot's machine enable bit. At user level they need both the machine and the supervisor enable bits.
- R10: Any write to the alias regions is illegal and changes no counter.
- R11: An illegal access returns read data 0, asserts `csr_illegal_o` and changes no state.
- R12: After reset, all counters, selectors and masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT | Event pulses. Bit k is code k+1: icache miss, dcache miss, iTLB miss, dTLB miss, load, store, exception, exception return, branch, mispredict, branch exception, call, return, store buffer full, fetch empty, icache access, dcache access, line invalidate, iTLB flush, integer op, float op, bubble |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| csr_req_i | input | 1 | Register access this cycle |
| csr_we_i | input | 1 | The access is a write |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data, 0 when illegal |
| csr_illegal_o | output | 1 | Access refused |

## Verification
The hardest situation to reach is a counter changing in the same cycle that software touches it. This covers a write racing an increment, and a low-word wrap that must carry into the separately addressed high word. The stimulus gets there by letting the free-running cycle counter run and writing all ones into its low word. It then reads the low word, the high word and the low word again on consecutive cycles, which shows the write winning, then the carry, then further counting. The selector mapping is swept over codes 0 to 25. Each event input is pulsed a number of cycles equal to its own code, so the count identifies which input was chosen.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int NSLOT = 9;
  localparam logic [NSLOT-1:0] SLOT_MASK = 9'h1FD;
  localparam logic [4:0] FIRST_GEN = 5'd3;
  localparam logic [4:0] LAST_SLOT = 5'd8;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    K_NONE, K_CTR_LO, K_CTR_HI, K_SEL, K_INH, K_MEN, K_SEN
  } kind_e;

  localparam logic [2:0] RG_CTR_LO = 3'd0;
  localparam logic [2:0] RG_CTR_HI = 3'd1;
  localparam logic [2:0] RG_ALI_LO = 3'd2;
  localparam logic [2:0] RG_ALI_HI = 3'd3;
  localparam logic [2:0] RG_SEL    = 3'd4;
  localparam logic [2:0] RG_CTRL   = 3'd5;

  // write has priority over the increment
  function automatic logic [63:0] next_count(input logic [63:0] cur, input logic inc,
                                             input logic wr, input logic [63:0] wval);
    if (wr) return wval;
    return cur + {63'd0, inc};
  endfunction
endpackage

// File: rtl/hpm_event_sel.sv
module hpm_event_sel #(
  parameter int NUM_EVT = 22,
  parameter int SEL_W   = 5
) (
  input  logic [SEL_W-1:0]   code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (code_i == SEL_W'(k + 1)) hit_o = evt_i[k];
    end
  end
endmodule

// File: rtl/hpm_counter.sv
module hpm_counter
  import hpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inc_i,
  input  logic        wr_i,
  input  logic [63:0] wval_i,
  output logic [63:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= next_count(q_o, inc_i, wr_i, wval_i);
  end
endmodule

// File: rtl/hpm_access.sv
module hpm_access
  import hpm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [11:0]      addr_i,
  input  logic [1:0]       priv_i,
  input  logic [NSLOT-1:0] men_i,
  input  logic [NSLOT-1:0] sen_i,
  output kind_e            kind_o,
  output logic [4:0]       slot_o,
  output logic             ok_o,
  output logic             illegal_o
);
  localparam logic HAS_HI = (XLEN == 32);

  logic [2:0] region;
  logic       top_zero, slot_ctr, slot_gen, is_mach, is_super, men_bit, sen_bit, may_read;
  logic       legal;

  assign region   = addr_i[7:5];
  assign top_zero = (addr_i[11:8] == 4'd0);
  assign slot_o   = addr_i[4:0];
  assign slot_ctr = (slot_o <= LAST_SLOT) && (slot_o != 5'd1);
  assign slot_gen = (slot_o >= FIRST_GEN) && (slot_o <= LAST_SLOT);
  assign is_mach  = (priv_i == PRIV_MACH);
  assign is_super = (priv_i == PRIV_SUPER);

  always_comb begin
    men_bit = 1'b0;
    sen_bit = 1'b0;
    for (int n = 0; n < NSLOT; n++) begin
      if (slot_o == 5'(n)) begin
        men_bit = men_i[n];
        sen_bit = sen_i[n];
      end
    end
  end

  assign may_read = is_mach | (is_super & men_bit) | (!is_mach & !is_super & men_bit & sen_bit);

  always_comb begin
    kind_o = K_NONE;
    legal  = 1'b0;
    if (top_zero) begin
      unique case (region)
        RG_CTR_LO: begin kind_o = K_CTR_LO; legal = slot_ctr & is_mach; end
        RG_CTR_HI: begin kind_o = K_CTR_HI; legal = slot_ctr & is_mach & HAS_HI; end
        RG_ALI_LO: begin kind_o = K_CTR_LO; legal = slot_ctr & !we_i & may_read; end
        RG_ALI_HI: begin kind_o = K_CTR_HI; legal = slot_ctr & !we_i & may_read & HAS_HI; end
        RG_SEL:    begin kind_o = K_SEL;    legal = slot_gen & is_mach; end
        RG_CTRL: begin
          if (slot_o == 5'd0)      begin kind_o = K_INH; legal = is_mach; end
          else if (slot_o == 5'd1) begin kind_o = K_MEN; legal = is_mach; end
          else if (slot_o == 5'd2) begin kind_o = K_SEN; legal = is_mach | is_super; end
        end
        default: legal = 1'b0;
      endcase
    end
  end

  assign ok_o      = req_i & legal;
  assign illegal_o = req_i & !legal;
endmodule

// File: rtl/hpm_unit.sv
module hpm_unit
  import hpm_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_EVT = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               retire_i,
  input  logic [1:0]         priv_i,
  input  logic               csr_req_i,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               csr_illegal_o
);
  localparam int SEL_W = $clog2(NUM_EVT + 1);

  kind_e            kind;
  logic [4:0]       slot;
  logic             acc_ok, acc_wr;
  logic [NSLOT-1:0] inh_q, men_q, sen_q;
  logic [NSLOT-1:0] wr_slot, inc_slot;
  logic [63:0]      cnt    [NSLOT];
  logic [63:0]      wr_val [NSLOT];
  logic [SEL_W-1:0] sel_q  [NSLOT];
  logic [SEL_W-1:0] sel_wcode;
  logic [63:0]      cnt_pick;
  logic [SEL_W-1:0] sel_pick;

  hpm_access #(.XLEN(XLEN)) u_access (
    .req_i     (csr_req_i),
    .we_i      (csr_we_i),
    .addr_i    (csr_addr_i),
    .priv_i    (priv_i),
    .men_i     (men_q),
    .sen_i     (sen_q),
    .kind_o    (kind),
    .slot_o    (slot),
    .ok_o      (acc_ok),
    .illegal_o (csr_illegal_o)
  );

  assign acc_wr    = acc_ok & csr_we_i;
  assign sel_wcode = (csr_wdata_i <= XLEN'(NUM_EVT)) ? csr_wdata_i[SEL_W-1:0] : '0;

  // control masks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q <= '0;
      men_q <= '0;
      sen_q <= '0;
    end else if (acc_wr) begin
      if (kind == K_INH) inh_q <= csr_wdata_i[NSLOT-1:0] & SLOT_MASK;
      if (kind == K_MEN) men_q <= csr_wdata_i[NSLOT-1:0] & SLOT_MASK;
      if (kind == K_SEN) sen_q <= csr_wdata_i[NSLOT-1:0] & SLOT_MASK;
    end
  end

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    if (n == 1) begin : g_hole
      assign cnt[n]      = '0;
      assign wr_val[n]   = '0;
      assign wr_slot[n]  = 1'b0;
      assign inc_slot[n] = 1'b0;
      assign sel_q[n]    = '0;
    end else begin : g_ctr
      assign wr_slot[n] = acc_wr && (kind == K_CTR_LO || kind == K_CTR_HI) && (slot == 5'(n));

      if (XLEN == 32) begin : g_split
        assign wr_val[n] = (kind == K_CTR_HI) ? {csr_wdata_i[31:0], cnt[n][31:0]}
                                              : {cnt[n][63:32], csr_wdata_i[31:0]};
      end else begin : g_full
        assign wr_val[n] = 64'(csr_wdata_i);
      end

      if (n == 0) begin : g_cyc
        assign sel_q[n]    = '0;
        assign inc_slot[n] = ~inh_q[n];
      end else if (n == 2) begin : g_ret
        assign sel_q[n]    = '0;
        assign inc_slot[n] = retire_i & ~inh_q[n];
      end else begin : g_gen
        logic hit;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sel_q[n] <= '0;
          else if (acc_wr && kind == K_SEL && slot == 5'(n)) sel_q[n] <= sel_wcode;
        end
        hpm_event_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
          .code_i (sel_q[n]),
          .evt_i  (evt_i),
          .hit_o  (hit)
        );
        assign inc_slot[n] = hit & ~inh_q[n];
      end

      hpm_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc_slot[n]),
        .wr_i   (wr_slot[n]),
        .wval_i (wr_val[n]),
        .q_o    (cnt[n])
      );
    end
  end

  always_comb begin
    cnt_pick = '0;
    sel_pick = '0;
    for (int n = 0; n < NSLOT; n++) begin
      if (slot == 5'(n)) begin
        cnt_pick = cnt[n];
        sel_pick = sel_q[n];
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    if (acc_ok) begin
      unique case (kind)
        K_CTR_LO: csr_rdata_o = XLEN'(cnt_pick);
        K_CTR_HI: csr_rdata_o = XLEN'(cnt_pick[63:32]);
        K_SEL:    csr_rdata_o = XLEN'(sel_pick);
        K_INH:    csr_rdata_o = XLEN'(inh_q);
        K_MEN:    csr_rdata_o = XLEN'(men_q);
        K_SEN:    csr_rdata_o = XLEN'(sen_q);
        default:  csr_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/hpm_unit_chk.sv
module hpm_unit_chk
  import hpm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_req,
  input logic             csr_we,
  input logic [11:0]      csr_addr,
  input logic [1:0]       priv,
  input logic             csr_illegal,
  input logic [XLEN-1:0]  csr_rdata,
  input logic [NSLOT-1:0] inh,
  input logic [NSLOT-1:0] wr_slot,
  input logic [63:0]      cnt    [NSLOT],
  input logic [63:0]      wr_val [NSLOT]
);
  logic alias_wr, mach_only;
  assign alias_wr  = csr_req && csr_we && (csr_addr[11:8] == 4'd0) &&
                     (csr_addr[7:5] == RG_ALI_LO || csr_addr[7:5] == RG_ALI_HI);
  assign mach_only = csr_req && (priv != PRIV_MACH) && (csr_addr[11:8] == 4'd0) &&
                     (csr_addr[7:5] == RG_CTR_LO || csr_addr[7:5] == RG_CTR_HI ||
                      csr_addr[7:5] == RG_SEL);

  a_r10_alias_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    alias_wr |-> csr_illegal);

  a_r8_machine_region: assert property (@(posedge clk) disable iff (!rst_n)
    mach_only |-> csr_illegal);

  a_r11_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));

  a_r11_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (wr_slot == '0));

  a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh[0] && !wr_slot[0]) |=> (cnt[0] == $past(cnt[0]) + 64'd1));

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    if (n != 1) begin : g_chk
      a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inh[n] && !wr_slot[n]) |=> $stable(cnt[n]));
      a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_slot[n] |=> (cnt[n] == $past(wr_val[n])));
    end
  end
endmodule

bind hpm_unit hpm_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_req     (csr_req_i),
  .csr_we      (csr_we_i),
  .csr_addr    (csr_addr_i),
  .priv        (priv_i),
  .csr_illegal (csr_illegal_o),
  .csr_rdata   (csr_rdata_o),
  .inh         (inh_q),
  .wr_slot     (wr_slot),
  .cnt         (cnt),
  .wr_val      (wr_val)
);

// File: tb/test_hpm_unit.sv
module test_hpm_unit;
  localparam int NE = 22;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;
  localparam logic [11:0] A_CLO = 12'h000, A_CHI = 12'h020, A_ALO = 12'h040,
                          A_AHI = 12'h060, A_SEL = 12'h080, A_INH = 12'h0A0,
                          A_MEN = 12'h0A1, A_SEN = 12'h0A2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic retire = 1'b0, req = 1'b0, we = 1'b0;
  logic [1:0] priv = PM;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic illegal;
  int nchk = 0, nerr = 0;
  logic [63:0] expg [9];

  always #2 clk = ~clk;

  hpm_unit i_hpm_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .retire_i(retire), .priv_i(priv),
    .csr_req_i(req), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .csr_illegal_o(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] p, input logic w, input logic [11:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic ill);
    @(negedge clk);
    priv = p; req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    rd = rdata; ill = illegal;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic mwr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; logic ill;
    acc(PM, 1'b1, a, d, rd, ill);
    if (ill) begin nerr++; $display("FAIL R1 write %0h refused actual=1 expected=0", a); end
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] p, input logic [11:0] a,
                        input logic exp_ill, input logic [31:0] exp_d);
    logic [31:0] rd; logic ill;
    acc(p, 1'b0, a, 32'd0, rd, ill);
    chk(tag, {31'd0, ill}, {31'd0, exp_ill});
    chk(tag, {32'd0, rd}, {32'd0, exp_d});
  endtask

  task automatic pulse(input int b, input int len);
    @(negedge clk); evt[b] = 1'b1;
    repeat (len) @(negedge clk);
    evt[b] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic ill;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R12 reset values
    rd_chk("R12 gen counter", PM, A_CLO + 12'd3, 1'b0, 32'd0);
    rd_chk("R12 instret", PM, A_CLO + 12'd2, 1'b0, 32'd0);
    rd_chk("R12 selector", PM, A_SEL + 12'd5, 1'b0, 32'd0);
    rd_chk("R12 freeze mask", PM, A_INH, 1'b0, 32'd0);
    rd_chk("R12 enable mask", PM, A_MEN, 1'b0, 32'd0);

    // R5 mask bit 1 hardwired
    mwr(A_INH, 32'h1FF);
    rd_chk("R5 mask readback", PM, A_INH, 1'b0, 32'h1FD);

    // R2 cycle counting
    mwr(A_CLO, 32'd0); mwr(A_CHI, 32'd0);
    mwr(A_INH, 32'h1FC);
    repeat (9) @(posedge clk);
    mwr(A_INH, 32'h1FD);
    rd_chk("R2 cycle count", PM, A_CLO, 1'b0, 32'd10);

    // R2 retired count, R5 cycle held
    mwr(A_CLO + 12'd2, 32'd0); mwr(A_CHI + 12'd2, 32'd0);
    mwr(A_INH, 32'h1F9);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); retire = 1'b1;
      @(negedge clk); retire = 1'b0;
      @(negedge clk);
    end
    mwr(A_INH, 32'h1FD);
    rd_chk("R2 instret count", PM, A_CLO + 12'd2, 1'b0, 32'd5);
    rd_chk("R5 cycle frozen", PM, A_CLO, 1'b0, 32'd10);

    // R3 R4 selector sweep on counter 3
    mwr(A_INH, 32'h1F5);
    for (int c = 0; c < 26; c++) begin
      mwr(A_SEL + 12'd3, 32'(c));
      rd_chk("R4 selector readback", PM, A_SEL + 12'd3, 1'b0, (c <= NE) ? 32'(c) : 32'd0);
      mwr(A_CLO + 12'd3, 32'd0);
      for (int b = 0; b < NE; b++) pulse(b, b + 1);
      rd_chk("R3 selected event count", PM, A_CLO + 12'd3, 1'b0,
             (c >= 1 && c <= NE) ? 32'(c) : 32'd0);
    end

    // R3 all six counters at once
    mwr(A_INH, 32'h005);
    for (int n = 3; n < 9; n++) begin
      mwr(A_SEL + 12'(n), 32'(n + 12));
      mwr(A_CLO + 12'(n), 32'd0);
      expg[n] = 64'(39 / (n + 13) + 1);
    end
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      for (int k = 0; k < NE; k++) evt[k] = ((t % (k + 2)) == 0);
    end
    @(negedge clk); evt = '0;
    for (int n = 3; n < 9; n++)
      rd_chk("R3 parallel count", PM, A_CLO + 12'(n), 1'b0, expg[n][31:0]);

    // R5 freeze one general counter
    mwr(A_INH, 32'h025);
    @(negedge clk); evt = '1;
    repeat (6) @(negedge clk);
    evt = '0;
    mwr(A_INH, 32'h1FD);
    for (int n = 3; n < 9; n++) begin
      if (n != 5) expg[n] = expg[n] + 64'd6;
      rd_chk("R5 freeze general", PM, A_CLO + 12'(n), 1'b0, expg[n][31:0]);
    end

    // R6 write beats increment, R7 carry and half writes
    mwr(A_CHI, 32'd0);
    mwr(A_INH, 32'h1FC);
    mwr(A_CLO, 32'hFFFF_FFFF);
    rd_chk("R6 write wins", PM, A_CLO, 1'b0, 32'hFFFF_FFFF);
    rd_chk("R7 carry to high", PM, A_CHI, 1'b0, 32'd1);
    rd_chk("R7 low after wrap", PM, A_CLO, 1'b0, 32'd1);
    mwr(A_INH, 32'h1FD);
    mwr(A_CHI, 32'h0000_ABCD);
    rd_chk("R7 high write keeps low", PM, A_CLO, 1'b0, 32'd3);
    rd_chk("R7 high written", PM, A_CHI, 1'b0, 32'h0000_ABCD);
    mwr(A_CLO, 32'h0000_0042);
    rd_chk("R7 low write keeps high", PM, A_CHI, 1'b0, 32'h0000_ABCD);

    // R9 privilege gating of alias reads
    rd_chk("R9 super denied", PS, A_ALO + 12'd4, 1'b1, 32'd0);
    rd_chk("R9 machine alias", PM, A_ALO + 12'd4, 1'b0, expg[4][31:0]);
    mwr(A_MEN, 32'h010);
    rd_chk("R9 super allowed", PS, A_ALO + 12'd4, 1'b0, expg[4][31:0]);
    rd_chk("R9 user denied", PU, A_ALO + 12'd4, 1'b1, 32'd0);
    acc(PS, 1'b1, A_SEN, 32'h010, rd, ill);
    chk("R8 super writes its mask", {63'd0, ill}, 64'd0);
    rd_chk("R9 user allowed", PU, A_ALO + 12'd4, 1'b0, expg[4][31:0]);
    rd_chk("R9 user alias high", PU, A_AHI + 12'd4, 1'b0, 32'd0);
    rd_chk("R9 user other slot", PU, A_ALO + 12'd3, 1'b1, 32'd0);

    // R10 alias read-only
    acc(PM, 1'b1, A_ALO + 12'd3, 32'h1234, rd, ill);
    chk("R10 alias write refused", {63'd0, ill}, 64'd1);
    rd_chk("R10 counter unchanged", PM, A_CLO + 12'd3, 1'b0, expg[3][31:0]);

    // R8 machine-only regions, R11 no state change
    rd_chk("R8 super counter read", PS, A_CLO + 12'd3, 1'b1, 32'd0);
    acc(PS, 1'b1, A_INH, 32'h0, rd, ill);
    chk("R8 super mask write", {63'd0, ill}, 64'd1);
    rd_chk("R11 mask unchanged", PM, A_INH, 1'b0, 32'h1FD);
    acc(PU, 1'b1, A_SEN, 32'h0, rd, ill);
    chk("R8 user enable write", {63'd0, ill}, 64'd1);
    rd_chk("R11 enable unchanged", PM, A_SEN, 1'b0, 32'h010);
    acc(2'd2, 1'b1, A_SEL + 12'd4, 32'd1, rd, ill);
    chk("R8 reserved level write", {63'd0, ill}, 64'd1);
    rd_chk("R11 selector unchanged", PM, A_SEL + 12'd4, 1'b0, 32'd16);

    // R1 unmapped addresses
    rd_chk("R1 slot one", PM, A_CLO + 12'd1, 1'b1, 32'd0);
    rd_chk("R1 slot nine", PM, A_CLO + 12'd9, 1'b1, 32'd0);
    rd_chk("R1 selector slot two", PM, A_SEL + 12'd2, 1'b1, 32'd0);
    rd_chk("R1 control slot three", PM, A_INH + 12'd3, 1'b1, 32'd0);
    rd_chk("R1 region six", PM, 12'h0C0, 1'b1, 32'd0);
    rd_chk("R1 upper bits", PM, 12'h100, 1'b1, 32'd0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule